// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block sits in the write path of a byte-wide nonvolatile memory, between the host write stream and the page loader. It watches every accepted write for two keyed command sequences. A three-write sequence sets a sticky protect flag. A six-write sequence clears it. Each accepted write falls into one of three classes:

- A command write is consumed and never reaches the array.
- An authorised write is forwarded to the loader in the same cycle.
- A blocked write is consumed and raises a dummy write-cycle request, so the host sees a busy period but nothing is stored.

A change of protect state only takes effect when the external programming timer reports the end of the write cycle. Completing a sequence also raises the write-cycle request, so the change completes even if no data follows.

The write stream is valid/ready. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` follows the loader's `pass_ready` for every write, whatever its class, so back-pressure from the loader stalls the matcher as well. While `wr_ready` is low, a pending write neither advances the matcher nor produces any output. An authorised write appears on `pass_valid` with its address and data in the cycle it is accepted.

Top module: `wp_unlock_guard`

## Requirements
- R1: After reset, `prot_on` is 0, and with no write offered `pass_valid` and `busy_req` are 0.
- R2: With protection off, a write that is not part of a command sequence is forwarded in the same cycle: `pass_valid`=1 with unchanged address and data, and `busy_req`=0.
- R3: The set sequence is data 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Its writes are never forwarded, and the last one raises `busy_req` for one cycle. `prot_on` becomes 1 on the clock edge where `prog_done` is high, not before.
- R4: With protection on and no sequence pending, a write gives `pass_valid`=0 and `busy_req`=1, and `prot_on` stays 1.
- R5: After a completed set sequence, later writes are forwarded, whatever the protect state, until the next `prog_done`. After that, writes under protection are blocked again.
- R6: The clear sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. All six writes are consumed, the sixth raises `busy_req`, and `prot_on` becomes 0 on the `prog_done` edge.
- R7: A write that does not match the expected next step returns the matcher to idle, and that write is classified as an ordinary write under the current protect state.
- R8: Only address bits 14:0 take part in command matching. Higher bits are ignored.
- R9: A high `prot_clr` at a clock edge forces `prot_on` to 0 and drops any partial or pending sequence.
- R10: `wr_ready` equals `pass_ready`. A write offered while `wr_ready` is 0 does not advance the matcher.
- R11: A `prog_done` with no completed sequence pending leaves `prot_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_clr | input | 1 | Synchronous force of protection to disabled (fresh device) |
| wr_valid | input | 1 | Host write request valid |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| wr_addr | input | ADDR_W (19) | Write byte address |
| wr_data | input | 8 | Write data byte |
| pass_ready | input | 1 | Page loader can take a write |
| pass_valid | output | 1 | Authorised write forwarded to the loader |
| pass_addr | output | ADDR_W (19) | Forwarded address |
| pass_data | output | 8 | Forwarded data |
| prog_done | input | 1 | One-cycle pulse at the end of a programming period |
| busy_req | output | 1 | One-cycle request to start a write-cycle period |
| prot_on | output | 1 | Protect flag |

## Verification
The bench probes the moment the flag changes: it checks `prot_on` both after the last command write and after `prog_done`. A design that updated the flag at sequence completion would fail there. A broken sequence is followed by a write that would be a command step if the matcher had kept state, so a matcher that does not return to idle turns a blocked write into a swallowed one. Sequences sent with upper address bits set catch a compare over the full address. A command step held while back-pressure is active catches a matcher that advances on an unaccepted write. A `prog_done` with nothing pending, and a forced clear, catch a flag that toggles instead of being set and cleared.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned CMP_W = 15;
  localparam logic [CMP_W-1:0] ADR_HI = 15'h5555;
  localparam logic [CMP_W-1:0] ADR_LO = 15'h2AAA;
  localparam logic [7:0] KEY_A   = 8'hAA;
  localparam logic [7:0] KEY_B   = 8'h55;
  localparam logic [7:0] KEY_SET = 8'hA0;
  localparam logic [7:0] KEY_EXT = 8'h80;
  localparam logic [7:0] KEY_CLR = 8'h20;

  typedef enum logic [2:0] {
    M_IDLE, M_S1, M_S2, M_S3, M_S4, M_S5
  } mstate_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_SET, OP_CLR
  } pend_e;

  typedef enum logic [1:0] {
    K_CMD, K_DATA, K_BLOCK
  } kind_e;
endpackage

// File: rtl/wpg_matcher.sv
module wpg_matcher
  import wpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc,
  input  logic             hold,
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [7:0]       data,
  output logic             is_cmd,
  output logic             fin_set,
  output logic             fin_clr
);
  mstate_e st_q, st_d;
  logic    hit;

  always_comb begin
    hit     = 1'b0;
    fin_set = 1'b0;
    fin_clr = 1'b0;
    st_d    = M_IDLE;
    unique case (st_q)
      M_IDLE: if (addr_lo == ADR_HI && data == KEY_A) begin hit = 1'b1; st_d = M_S1; end
      M_S1:   if (addr_lo == ADR_LO && data == KEY_B) begin hit = 1'b1; st_d = M_S2; end
      M_S2:   if (addr_lo == ADR_HI && data == KEY_SET) begin
                hit = 1'b1; fin_set = 1'b1; st_d = M_IDLE;
              end else if (addr_lo == ADR_HI && data == KEY_EXT) begin
                hit = 1'b1; st_d = M_S3;
              end
      M_S3:   if (addr_lo == ADR_HI && data == KEY_A) begin hit = 1'b1; st_d = M_S4; end
      M_S4:   if (addr_lo == ADR_LO && data == KEY_B) begin hit = 1'b1; st_d = M_S5; end
      M_S5:   if (addr_lo == ADR_HI && data == KEY_CLR) begin
                hit = 1'b1; fin_clr = 1'b1; st_d = M_IDLE;
              end
      default: st_d = M_IDLE;
    endcase
    if (hold) begin
      hit     = 1'b0;
      fin_set = 1'b0;
      fin_clr = 1'b0;
      st_d    = M_IDLE;
    end
    is_cmd = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= M_IDLE;
    else if (clr)     st_q <= M_IDLE;
    else if (acc)     st_q <= st_d;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !clr) |=> $stable(st_q));

  // R7
  miss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_cmd && !clr) |=> (st_q == M_IDLE));
endmodule

// File: rtl/wpg_state.sv
module wpg_state
  import wpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic acc,
  input  logic fin_set,
  input  logic fin_clr,
  input  logic prog_done,
  output logic prot,
  output logic armed
);
  pend_e pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot   <= 1'b0;
      armed  <= 1'b0;
      pend_q <= OP_NONE;
    end else if (clr) begin
      prot   <= 1'b0;
      armed  <= 1'b0;
      pend_q <= OP_NONE;
    end else begin
      if (prog_done) begin
        armed  <= 1'b0;
        pend_q <= OP_NONE;
        if (pend_q == OP_SET) prot <= 1'b1;
        if (pend_q == OP_CLR) prot <= 1'b0;
      end
      if (acc && fin_set) begin
        armed  <= 1'b1;
        pend_q <= OP_SET;
      end else if (acc && fin_clr) begin
        armed  <= 1'b1;
        pend_q <= OP_CLR;
      end
    end
  end

  // R3
  set_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot) |-> $past(prog_done));

  // R6
  clr_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot) |-> ($past(prog_done) || $past(clr)));

  // R5
  arm_after_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(acc && (fin_set || fin_clr)));
endmodule

// File: rtl/wp_unlock_guard.sv
module wp_unlock_guard
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_clr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              pass_ready,
  output logic              pass_valid,
  output logic [ADDR_W-1:0] pass_addr,
  output logic [7:0]        pass_data,
  input  logic              prog_done,
  output logic              busy_req,
  output logic              prot_on
);
  logic  acc, is_cmd, fin_set, fin_clr, armed;
  kind_e kind;

  assign wr_ready = pass_ready;
  assign acc      = wr_valid && wr_ready;

  wpg_matcher u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (prot_clr),
    .acc     (acc),
    .hold    (armed),
    .addr_lo (wr_addr[CMP_W-1:0]),
    .data    (wr_data),
    .is_cmd  (is_cmd),
    .fin_set (fin_set),
    .fin_clr (fin_clr)
  );

  wpg_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (prot_clr),
    .acc       (acc),
    .fin_set   (fin_set),
    .fin_clr   (fin_clr),
    .prog_done (prog_done),
    .prot      (prot_on),
    .armed     (armed)
  );

  always_comb begin
    if (is_cmd)                kind = K_CMD;
    else if (!prot_on || armed) kind = K_DATA;
    else                       kind = K_BLOCK;
  end

  assign pass_valid = wr_valid && (kind == K_DATA);
  assign pass_addr  = wr_addr;
  assign pass_data  = wr_data;
  assign busy_req   = acc && ((kind == K_BLOCK) || (kind == K_CMD && (fin_set || fin_clr)));

  // R4
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_valid && busy_req));

  // R11
  prot_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_done && !prot_clr) |=> $stable(prot_on));
endmodule

// File: tb/test_wp_unlock_guard.sv
module test_wp_unlock_guard;
  localparam int ADDR_W = 19;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              prot_clr = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              pass_ready = 1'b1;
  logic              pass_valid;
  logic [ADDR_W-1:0] pass_addr;
  logic [7:0]        pass_data;
  logic              prog_done = 1'b0;
  logic              busy_req;
  logic              prot_on;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic              pass;
    logic              busy;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
    string             tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  wp_unlock_guard #(.ADDR_W(ADDR_W)) i_wp_unlock_guard (
    .clk(clk), .rst_n(rst_n), .prot_clr(prot_clr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .pass_ready(pass_ready), .pass_valid(pass_valid), .pass_addr(pass_addr),
    .pass_data(pass_data), .prog_done(prog_done), .busy_req(busy_req), .prot_on(prot_on)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per accepted write
  always @(negedge clk) begin
    #2;
    if (wr_valid && wr_ready) begin
      if (sb.size() == 0) begin
        check("unexpected write", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " pass"}, pass_valid, e.pass);
        check({e.tag, " busy"}, busy_req, e.busy);
        if (e.pass) begin
          check({e.tag, " addr"}, pass_addr, e.addr);
          check({e.tag, " data"}, pass_data, e.data);
        end
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                    input logic ep, input logic eb, input string tag);
    exp_t e;
    @(negedge clk);
    e.pass = ep; e.busy = eb; e.addr = a; e.data = d; e.tag = tag;
    sb.push_back(e);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
    #1;
  endtask

  task automatic seq_set(input logic [ADDR_W-1:0] hi, input string tag);
    wr(19'h05555 | hi, 8'hAA, 0, 0, tag);
    wr(19'h02AAA | hi, 8'h55, 0, 0, tag);
    wr(19'h05555 | hi, 8'hA0, 0, 1, tag);
  endtask

  initial begin
    #200000;
    check("R0 watchdog", 1, 0);
    done = 1'b1;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 prot", prot_on, 0);
    check("R1 pass", pass_valid, 0);
    check("R1 busy", busy_req, 0);
    rst_n = 1'b1;

    // R2 unprotected ordinary write
    wr(19'h00123, 8'h11, 1, 0, "R2 plain");

    // R3 set sequence, flag waits for prog_done
    seq_set(19'h0, "R3 set");
    #1 check("R3 prot before done", prot_on, 0);
    wr(19'h10000, 8'h5A, 1, 0, "R5 armed data");
    pulse_done();
    check("R3 prot after done", prot_on, 1);

    // R4 blocked write
    wr(19'h00040, 8'h77, 0, 1, "R4 blocked");
    #1 check("R4 prot kept", prot_on, 1);

    // R11 stray prog_done
    pulse_done();
    check("R11 prot steady", prot_on, 1);

    // R7 mismatch then ordinary classification
    wr(19'h05555, 8'hAA, 0, 0, "R7 step1");
    wr(19'h02AAA, 8'h33, 0, 1, "R7 miss blocked");

    // R5 authorised window closes on prog_done
    seq_set(19'h0, "R5 set");
    wr(19'h00200, 8'hC3, 1, 0, "R5 data");
    wr(19'h00201, 8'h3C, 1, 0, "R5 data2");
    pulse_done();
    wr(19'h00202, 8'h99, 0, 1, "R5 after window");

    // R8 upper address bits ignored
    seq_set(19'h70000, "R8 high bits");
    pulse_done();
    check("R8 prot", prot_on, 1);

    // R10 back-pressure does not advance matcher
    @(negedge clk);
    pass_ready = 1'b0;
    wr_valid = 1'b1; wr_addr = 19'h05555; wr_data = 8'hAA;
    #1 check("R10 ready mirrors", wr_ready, 0);
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    pass_ready = 1'b1;
    wr(19'h02AAA, 8'h55, 0, 1, "R10 no advance");

    // R6 clear sequence
    wr(19'h05555, 8'hAA, 0, 0, "R6 c1");
    wr(19'h02AAA, 8'h55, 0, 0, "R6 c2");
    wr(19'h05555, 8'h80, 0, 0, "R6 c3");
    wr(19'h05555, 8'hAA, 0, 0, "R6 c4");
    wr(19'h02AAA, 8'h55, 0, 0, "R6 c5");
    wr(19'h05555, 8'h20, 0, 1, "R6 c6");
    #1 check("R6 prot before done", prot_on, 1);
    pulse_done();
    check("R6 prot after done", prot_on, 0);
    wr(19'h00321, 8'h42, 1, 0, "R2 after clear");

    // R9 forced clear
    seq_set(19'h0, "R9 set");
    pulse_done();
    check("R9 prot set", prot_on, 1);
    @(negedge clk); prot_clr = 1'b1;
    @(negedge clk); prot_clr = 1'b0;
    #1 check("R9 prot cleared", prot_on, 0);
    wr(19'h00444, 8'h0F, 1, 0, "R9 plain after clr");

    repeat (2) @(negedge clk);
    check("R0 scoreboard drained", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule